// File: doc/BRIEF.md
# Bootstrap Memory Copy Engine

This block keeps a short boot program in a small retention SRAM. That memory stays powered while the embedded processor sleeps. The block copies the program, one dword per clock, into the processor's instruction SRAM. The host loads the boot image through a register port and programs a source offset, a destination address and a dword count. It then sets a go bit. The go bit reads back as 1 for as long as the copy runs and clears by itself when the copy ends, so the host can poll it.

The host can also set an arm bit. While the arm bit is set, every power-management wake pulse re-runs the same copy with no host action. The processor-run output is low from the start of each copy until the last dword has been written, and it is then raised to let the processor execute the freshly copied program.

Top module: `boot_copy_engine`

## Requirements
- R1: Host writes with `reg_addr[4]`=1 store `reg_wdata` into retention-SRAM dword `reg_addr[3:0]`. Host reads at the same address return that dword on `reg_rdata` in the same cycle.
- R2: With `reg_addr[4]`=0, the registers are selected by `reg_addr[3:0]`: 0 is control (bit 0 go/busy, bit 1 arm), 1 is the source offset (4 bits), 2 is the destination (8 bits) and 3 is the dword count (5 bits). Unused bits read 0, and after reset every register reads 0.
- R3: A control write with bit 0 set while idle starts a copy. Bit 0 reads 1 from the clock edge that took the write. It reads 0 again exactly N+1 cycles later, where N is the count.
- R4: A copy of N dwords presents N instruction-SRAM writes on N consecutive cycles, the first one cycle after the start edge. Write k carries retention dword (src+k) mod 16 to address (dst+k) mod 256.
- R5: A count of 0 presents no instruction-SRAM write, ends one cycle after the start edge and still raises `cpu_run`.
- R6: `cpu_run` is 0 after reset. It falls at the start edge of every copy, stays 0 while any write is presented, and rises in the same cycle that go/busy clears.
- R7: While a copy runs, writes to the source, destination and count registers, and a further go request, have no effect.
- R8: A one-cycle `wake_evt` pulse starts a copy with the current configuration only when arm is 1. With arm at 0, the pulse is ignored.
- R9: A `wake_evt` pulse during a running copy is dropped. It neither lengthens nor restarts that copy.
- R10: Arm is written from control bit 1 on every control write, including writes made during a copy. It stays set across copies and wake events until the host writes it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 5 | Host address: bit 4 selects retention SRAM, otherwise register index |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` (combinational) |
| wake_evt | input | 1 | Power-management wake pulse |
| imem_we | output | 1 | Instruction-SRAM write enable |
| imem_addr | output | 8 | Instruction-SRAM dword address |
| imem_wdata | output | 32 | Instruction-SRAM write data |
| cpu_run | output | 1 | Processor release (1 = run) |

## Verification
A go write or wake pulse is taken at one edge. Busy reads 1 right after that edge, and the k-th instruction-SRAM write is due one edge later per dword. Busy clears and `cpu_run` rises N+1 edges after the start. The bench records the cycle index of the start at the falling edge after it, and logs every write with its cycle index. It then compares the first and last write cycle and the busy duration against these counts. Register and SRAM readback is combinational, so those values are sampled one delta after the address is set, between edges.

// File: rtl/bcopy_pkg.sv
package bcopy_pkg;
    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_ARM_BIT = 1;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_SRC  = 2'd1,
        SEL_DST  = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/bcopy_retention_ram.sv
module bcopy_retention_ram #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] host_addr_i,
    output logic [DW-1:0] host_data_o,
    input  logic [AW-1:0] copy_addr_i,
    output logic [DW-1:0] copy_data_o
);
    // Retention storage: deliberately not cleared by reset.
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign host_data_o = mem_q[host_addr_i];
    assign copy_data_o = mem_q[copy_addr_i];
endmodule

// File: rtl/bcopy_regs.sv
module bcopy_regs
    import bcopy_pkg::*;
#(
    parameter int BOOT_AW = 4,
    parameter int IMEM_AW = 8,
    parameter int CNT_W   = 5,
    parameter int RA_W    = 5,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [RA_W-1:0]    addr_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic               busy_i,
    input  logic [DW-1:0]      ram_rdata_i,
    output logic [DW-1:0]      rdata_o,
    output logic               ram_we_o,
    output logic               start_o,
    output logic               arm_o,
    output logic [BOOT_AW-1:0] src_o,
    output logic [IMEM_AW-1:0] dst_o,
    output logic [CNT_W-1:0]   cnt_o
);
    typedef struct packed {
        logic [BOOT_AW-1:0] src;
        logic [IMEM_AW-1:0] dst;
        logic [CNT_W-1:0]   cnt;
        logic               arm;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    logic     to_ram, reg_ok, ctl_wr;
    reg_sel_e sel;
    logic     unused_wdata;

    assign to_ram       = addr_i[RA_W-1];
    assign reg_ok       = !to_ram && (addr_i[RA_W-2:0] < (RA_W-1)'(4));
    assign sel          = reg_sel_e'(addr_i[1:0]);
    assign ctl_wr       = wr_i && reg_ok && (sel == SEL_CTRL);
    assign unused_wdata = ^wdata_i;

    always_comb begin
        cfg_d    = cfg_q;
        start_o  = 1'b0;
        ram_we_o = wr_i && to_ram;
        if (wr_i && reg_ok) begin
            case (sel)
                SEL_CTRL: begin
                    cfg_d.arm = wdata_i[CTRL_ARM_BIT];
                    start_o   = wdata_i[CTRL_GO_BIT] && !busy_i;
                end
                SEL_SRC: if (!busy_i) cfg_d.src = wdata_i[BOOT_AW-1:0];
                SEL_DST: if (!busy_i) cfg_d.dst = wdata_i[IMEM_AW-1:0];
                SEL_CNT: if (!busy_i) cfg_d.cnt = wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        if (to_ram) begin
            rdata_o = ram_rdata_i;
        end else if (reg_ok) begin
            case (sel)
                SEL_CTRL: begin
                    rdata_o[CTRL_GO_BIT]  = busy_i;
                    rdata_o[CTRL_ARM_BIT] = cfg_q.arm;
                end
                SEL_SRC: rdata_o[BOOT_AW-1:0] = cfg_q.src;
                SEL_DST: rdata_o[IMEM_AW-1:0] = cfg_q.dst;
                SEL_CNT: rdata_o[CNT_W-1:0]   = cfg_q.cnt;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign arm_o = cfg_q.arm;
    assign src_o = cfg_q.src;
    assign dst_o = cfg_q.dst;
    assign cnt_o = cfg_q.cnt;

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> ($stable(cfg_q.src) && $stable(cfg_q.dst) && $stable(cfg_q.cnt)));

    // R10
    arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.arm && !(ctl_wr && !wdata_i[CTRL_ARM_BIT])) |=> cfg_q.arm);
endmodule

// File: rtl/bcopy_seq.sv
module bcopy_seq #(
    parameter int BOOT_AW = 4,
    parameter int IMEM_AW = 8,
    parameter int CNT_W   = 5,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               wake_i,
    input  logic               arm_i,
    input  logic [BOOT_AW-1:0] src_i,
    input  logic [IMEM_AW-1:0] dst_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [DW-1:0]      ram_rdata_i,
    output logic [BOOT_AW-1:0] ram_raddr_o,
    output logic               busy_o,
    output logic               imem_we_o,
    output logic [IMEM_AW-1:0] imem_addr_o,
    output logic [DW-1:0]      imem_wdata_o,
    output logic               cpu_run_o
);
    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   left;
        logic [BOOT_AW-1:0] src;
        logic [IMEM_AW-1:0] dst;
        logic               we;
        logic [IMEM_AW-1:0] waddr;
        logic [DW-1:0]      wdata;
        logic               run;
    } seq_t;

    seq_t s_d, s_q;
    logic go;

    assign go = !s_q.busy && (start_i || (wake_i && arm_i));

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (!s_q.busy) begin
            if (go) begin
                s_d.busy = 1'b1;
                s_d.left = cnt_i;
                s_d.src  = src_i;
                s_d.dst  = dst_i;
                s_d.run  = 1'b0;
            end
        end else if (s_q.left == '0) begin
            s_d.busy = 1'b0;
            s_d.run  = 1'b1;
        end else begin
            s_d.we    = 1'b1;
            s_d.waddr = s_q.dst;
            s_d.wdata = ram_rdata_i;
            s_d.src   = s_q.src + 1'b1;
            s_d.dst   = s_q.dst + 1'b1;
            s_d.left  = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ram_raddr_o  = s_q.src;
    assign busy_o       = s_q.busy;
    assign imem_we_o    = s_q.we;
    assign imem_addr_o  = s_q.waddr;
    assign imem_wdata_o = s_q.wdata;
    assign cpu_run_o    = s_q.run;

    // R3
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy_o);

    // R6
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imem_we_o |-> !cpu_run_o);

    // R6
    run_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> cpu_run_o);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we_o && $past(imem_we_o)) |-> (imem_addr_o == $past(imem_addr_o) + 1'b1));

    // R9
    no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.left != '0) |=> (busy_o && imem_we_o));

    // R5
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.left == '0) |=> (!busy_o && !imem_we_o && cpu_run_o));
endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine #(
    parameter int  BOOT_DEPTH = 16,
    parameter int  IMEM_AW    = 8,
    parameter int  DW         = 32,
    localparam int BOOT_AW    = $clog2(BOOT_DEPTH),
    localparam int RA_W       = BOOT_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [RA_W-1:0]    reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic               wake_evt,
    output logic               imem_we,
    output logic [IMEM_AW-1:0] imem_addr,
    output logic [DW-1:0]      imem_wdata,
    output logic               cpu_run
);
    localparam int CNT_W = BOOT_AW + 1;

    logic               busy, ram_we, start, arm;
    logic [BOOT_AW-1:0] src, ram_raddr;
    logic [IMEM_AW-1:0] dst;
    logic [CNT_W-1:0]   cnt;
    logic [DW-1:0]      host_rd, copy_rd;

    bcopy_retention_ram #(.DEPTH(BOOT_DEPTH), .AW(BOOT_AW), .DW(DW)) u_ram (
        .clk         (clk),
        .wr_en_i     (ram_we),
        .wr_addr_i   (reg_addr[BOOT_AW-1:0]),
        .wr_data_i   (reg_wdata),
        .host_addr_i (reg_addr[BOOT_AW-1:0]),
        .host_data_o (host_rd),
        .copy_addr_i (ram_raddr),
        .copy_data_o (copy_rd)
    );

    bcopy_regs #(.BOOT_AW(BOOT_AW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W),
                 .RA_W(RA_W), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .busy_i      (busy),
        .ram_rdata_i (host_rd),
        .rdata_o     (reg_rdata),
        .ram_we_o    (ram_we),
        .start_o     (start),
        .arm_o       (arm),
        .src_o       (src),
        .dst_o       (dst),
        .cnt_o       (cnt)
    );

    bcopy_seq #(.BOOT_AW(BOOT_AW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W), .DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .wake_i       (wake_evt),
        .arm_i        (arm),
        .src_i        (src),
        .dst_i        (dst),
        .cnt_i        (cnt),
        .ram_rdata_i  (copy_rd),
        .ram_raddr_o  (ram_raddr),
        .busy_o       (busy),
        .imem_we_o    (imem_we),
        .imem_addr_o  (imem_addr),
        .imem_wdata_o (imem_wdata),
        .cpu_run_o    (cpu_run)
    );
endmodule

// File: tb/boot_copy_engine_bench.sv
module boot_copy_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wake_evt = 1'b0;
    logic        imem_we;
    logic [7:0]  imem_addr;
    logic [31:0] imem_wdata;
    logic        cpu_run;

    int n_chk = 0, n_bad = 0;
    int ncyc = 0, wcnt = 0, wfirst = 0, wlast = 0;
    bit done = 0;
    logic [31:0] imodel [256];

    always #10 clk = ~clk;

    boot_copy_engine u_boot_copy_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_evt(wake_evt),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .cpu_run(cpu_run)
    );

    always @(negedge clk) begin
        ncyc = ncyc + 1;
        if (imem_we) begin
            imodel[imem_addr] = imem_wdata;
            wcnt = wcnt + 1;
            if (wcnt == 1) wfirst = ncyc;
            wlast = ncyc;
        end
    end

    function automatic logic [31:0] bimg(input int i);
        return 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0111);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    task automatic set_cfg(input int s, input int d, input int n);
        wr(5'd1, 32'(s));
        wr(5'd2, 32'(d));
        wr(5'd3, 32'(n));
    endtask

    // Called at the falling edge right after the start edge.
    task automatic begin_obs(input string tag, output int s);
        logic [31:0] v;
        #1;
        s = ncyc;
        rd(5'd0, v);
        chk({tag, " R3 busy after start"}, {31'd0, v[0]}, 32'd1);
        chk({tag, " R6 run low at start"}, {31'd0, cpu_run}, 32'd0);
    endtask

    task automatic finish_obs(input string tag, input int n, input int src,
                              input int dst, input int s);
        logic [31:0] v;
        rd(5'd0, v);
        while (v[0]) begin
            @(negedge clk); #1;
            rd(5'd0, v);
        end
        chk({tag, " R3 busy duration"}, 32'(ncyc - s), 32'(n + 1));
        chk({tag, " R4 write count"}, 32'(wcnt), 32'(n));
        chk({tag, " R6 run after done"}, {31'd0, cpu_run}, 32'd1);
        if (n > 0) begin
            chk({tag, " R4 first write cycle"}, 32'(wfirst - s), 32'd1);
            chk({tag, " R4 last write cycle"}, 32'(wlast - s), 32'(n));
        end
        for (int i = 0; i < n; i++) begin
            chk({tag, " R4 data"}, imodel[(dst + i) % 256], bimg((src + i) % 16));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state
        for (int a = 0; a < 4; a++) begin
            rd(5'(a), v);
            chk("R2 reset register", v, 32'd0);
        end
        chk("R6 reset cpu_run", {31'd0, cpu_run}, 32'd0);
        chk("R4 reset imem_we", {31'd0, imem_we}, 32'd0);

        // R1: retention SRAM load and readback
        for (int i = 0; i < 16; i++) wr(5'(16 + i), bimg(i));
        for (int i = 0; i < 16; i++) begin
            rd(5'(16 + i), v);
            chk("R1 sram readback", v, bimg(i));
        end

        // R2: field widths
        wr(5'd1, 32'hFFFF_FFF3);
        wr(5'd2, 32'h0000_0123);
        wr(5'd3, 32'hFFFF_FFE7);
        rd(5'd1, v); chk("R2 src field", v, 32'h3);
        rd(5'd2, v); chk("R2 dst field", v, 32'h23);
        rd(5'd3, v); chk("R2 cnt field", v, 32'h7);
        rd(5'd4, v); chk("R2 unmapped reads 0", v, 32'h0);

        // R4/R5: sweep every count with varied offsets
        for (int n = 0; n <= 16; n++) begin
            int sv, dv;
            sv = (n * 5) % 16;
            dv = (n * 37 + 200) % 256;
            set_cfg(sv, dv, n);
            wcnt = 0;
            wr(5'd0, 32'd1);
            begin_obs(n == 0 ? "R5 sweep" : "R4 sweep", s);
            finish_obs(n == 0 ? "R5 sweep" : "R4 sweep", n, sv, dv, s);
        end

        // R7: config writes and a second go during a copy
        set_cfg(2, 10, 12);
        wcnt = 0;
        wr(5'd0, 32'd1);
        begin_obs("R7", s);
        wr(5'd1, 32'd9);
        wr(5'd2, 32'd99);
        wr(5'd3, 32'd3);
        wr(5'd0, 32'd1);
        finish_obs("R7", 12, 2, 10, s);
        rd(5'd1, v); chk("R7 src kept", v, 32'd2);
        rd(5'd2, v); chk("R7 dst kept", v, 32'd10);
        rd(5'd3, v); chk("R7 cnt kept", v, 32'd12);
        repeat (4) @(negedge clk);
        #1; rd(5'd0, v);
        chk("R7 no restart", {31'd0, v[0]}, 32'd0);
        chk("R7 no extra writes", 32'(wcnt), 32'd12);

        // R8: wake ignored while disarmed
        set_cfg(1, 50, 6);
        wcnt = 0;
        pulse_wake();
        repeat (3) @(negedge clk);
        #1; rd(5'd0, v);
        chk("R8 disarmed wake busy", v, 32'd0);
        chk("R8 disarmed wake writes", 32'(wcnt), 32'd0);

        // R10: arm without go
        wr(5'd0, 32'd2);
        #1; rd(5'd0, v);
        chk("R10 arm readback", v, 32'd2);

        // R8: armed wake runs the copy
        wcnt = 0;
        pulse_wake();
        begin_obs("R8 wake", s);
        finish_obs("R8 wake", 6, 1, 50, s);

        // R9: wake during a copy is dropped
        set_cfg(0, 120, 8);
        wcnt = 0;
        pulse_wake();
        begin_obs("R9", s);
        repeat (2) @(negedge clk);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        finish_obs("R9", 8, 0, 120, s);
        repeat (3) @(negedge clk);
        #1; rd(5'd0, v);
        chk("R9 no restart", {31'd0, v[0]}, 32'd0);
        chk("R9 write total", 32'(wcnt), 32'd8);

        // R10: arm still set after copies; clearing it disables wake
        rd(5'd0, v);
        chk("R10 arm sticky", v, 32'd2);
        wr(5'd0, 32'd0);
        #1; rd(5'd0, v);
        chk("R10 arm cleared", v, 32'd0);
        wcnt = 0;
        pulse_wake();
        repeat (3) @(negedge clk);
        #1; rd(5'd0, v);
        chk("R10 wake after clear busy", v, 32'd0);
        chk("R10 wake after clear writes", 32'(wcnt), 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule